// File: doc/BRIEF.md
# Packing UART Receive Buffer

This block is the bus-facing receive buffer of a UART. It sits between the serial receiver and a 32-bit processor bus. The receiver hands over one character at a time, each with an optional ninth bit. The block builds a 32-bit word from the characters. With packing off, each character becomes its own word. With packing on, two characters are joined into one word, so software needs half as many bus reads.

Software has two ways to read the buffer. The main address gives the word and consumes it, which clears the data-ready and overrun status. The shadow address gives the same word and changes no status, so a debugger or monitor can look at the buffer without disturbing the driver. The main address is also shared with two other registers:

- While the divisor-latch access bit is clear, a write to the main address becomes a transmit-holding write strobe for the transmitter.
- While that bit is set, both reads and writes at the main address go to the low divisor byte register.

Top module: `urb_top`

## Requirements
- R1: After reset, data_ready and overrun are 0, div_lo is 0, and a main-address read returns 0.
- R2: With pack_en low, each character completes a word. The 8 data bits go to bits 7:0 and the ninth bit to bit 8. All other bits read 0. data_ready is 1 from the clock edge that takes the character.
- R3: With pack_en high, the first character goes to bits 7:0 with its ninth bit at bit 8. The second character goes to bits 23:16 with its ninth bit at bit 24. Bits 15:9 and 31:25 read 0. data_ready stays 0 after the first character and becomes 1 only when the second character is taken.
- R4: A read at the main address (0x0) with dlab low returns the buffer word in the same cycle. On the next edge it clears data_ready and overrun.
- R5: A read at the shadow address (0x2) returns the same word as the main address and leaves data_ready and overrun unchanged.
- R6: A write at address 0x0 with dlab low raises tx_wr in the same cycle and leaves the buffer contents and status unchanged.
- R7: With dlab high, address 0x0 reaches the low divisor byte instead of the buffer:
  - A write loads bus_wdata[7:0] into div_lo on the next edge and gives no tx_wr.
  - A read returns div_lo zero-extended and does not clear data_ready.
- R8: If a word completes while data_ready is 1 and no main read happens in that cycle, overrun goes to 1 and the new word replaces the old one.
- R9: If a word completes in the same cycle as a main read, the read returns the old word. Afterwards data_ready stays 1, overrun is 0, and the buffer holds the new word.
- R10: If pack_en goes low while a first character is waiting for its partner, that waiting character is dropped. The next pairing, once pack_en is high again, starts from a fresh first character.
- R11: Reads at addresses other than 0x0 and 0x2 return 0. Writes to the shadow address change nothing and give no tx_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Receiver presents a character this cycle |
| rx_char | input | 8 | Received character data bits |
| rx_ninth | input | 1 | Ninth data bit of the character |
| pack_en | input | 1 | Join two characters per word |
| dlab | input | 1 | Divisor-latch access bit |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 4 | Bus register address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, valid in the cycle of bus_rd |
| data_ready | output | 1 | A complete word is waiting |
| overrun | output | 1 | A word was replaced before it was read |
| tx_wr | output | 1 | Write strobe for the transmit holding register |
| div_lo | output | 8 | Low divisor byte for the baud generator |

## Verification
The hardest case to reach from the ports is the same-cycle collision between a main read and the arrival of the character that completes a word. Here the clear has to lose to the set, and the overrun flag must stay down. The bench makes this happen by raising bus_rd and rx_valid on the same falling edge. It then checks the returned old word and, through the shadow address, the new word. A second hard case is a packing pair cut in half by pack_en going low. The bench sends one character in pack mode, drops pack_en, and sends another. It then checks that only the second character appears, and that the next pair lines up correctly.

// File: rtl/urb_pkg.sv
package urb_pkg;

    // which register a bus access reaches
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_BUF    = 2'd1,
        ACC_DIV    = 2'd2,
        ACC_SHADOW = 2'd3
    } acc_sel_e;

endpackage

// File: rtl/urb_packer.sv
module urb_packer #(
    parameter int CHAR_W = 8,
    parameter int WORD_W = 32,
    parameter int HI_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pack_en,
    input  logic              ch_valid,
    input  logic [CHAR_W-1:0] ch_data,
    input  logic              ch_ext,
    output logic              word_done,
    output logic [WORD_W-1:0] word
);
    localparam int SLOT_W = CHAR_W + 1;

    typedef struct packed {
        logic              half;
        logic [SLOT_W-1:0] lo;
    } pk_state_t;

    pk_state_t s_d, s_q;
    logic [SLOT_W-1:0] cur;

    always_comb begin
        s_d       = s_q;
        word_done = 1'b0;
        word      = '0;
        cur       = {ch_ext, ch_data};
        if (!pack_en) begin
            s_d.half = 1'b0;
        end
        if (ch_valid) begin
            if (!pack_en) begin
                word_done        = 1'b1;
                word[SLOT_W-1:0] = cur;
            end else if (!s_q.half) begin
                s_d.half = 1'b1;
                s_d.lo   = cur;
            end else begin
                word_done             = 1'b1;
                word[SLOT_W-1:0]      = s_q.lo;
                word[HI_LSB +: SLOT_W] = cur;
                s_d.half              = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3
    pair_needs_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && pack_en) |-> s_q.half);

    // R10
    pending_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pack_en |=> !s_q.half);

endmodule

// File: rtl/urb_status.sv
module urb_status #(
    parameter int WORD_W = 32,
    parameter int CHAR_W = 8,
    parameter int HI_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word,
    input  logic              consume,
    output logic [WORD_W-1:0] buf_val,
    output logic              ready,
    output logic              ovr
);
    localparam int SLOT_W = CHAR_W + 1;

    typedef struct packed {
        logic [WORD_W-1:0] buffer;
        logic              ready;
        logic              ovr;
    } st_state_t;

    st_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (word_done) begin
            s_d.buffer = word;
        end
        s_d.ready = word_done | (s_q.ready & ~consume);
        if (consume) begin
            s_d.ovr = 1'b0;
        end
        if (word_done && s_q.ready && !consume) begin
            s_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign buf_val = s_q.buffer;
    assign ready   = s_q.ready;
    assign ovr     = s_q.ovr;

    // R2
    ready_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> ready);

    // R4
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !word_done) |=> (!ready && !ovr));

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && ready && !consume) |=> ovr);

    // R9
    collide_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && consume) |=> (ready && !ovr));

    // R3
    gap_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_val[HI_LSB-1:SLOT_W] == '0) && (buf_val[WORD_W-1:HI_LSB+SLOT_W] == '0));

endmodule

// File: rtl/urb_bus_port.sv
module urb_bus_port
    import urb_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int WORD_W      = 32,
    parameter int DIV_W       = 8,
    parameter int ADDR_SHARED = 0,
    parameter int ADDR_SHADOW = 2,
    parameter int DIV_RST     = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dlab,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W-1:0] buf_val,
    output logic [WORD_W-1:0] rd_data,
    output logic              consume,
    output logic              tx_wr,
    output logic [DIV_W-1:0]  div_lo
);
    localparam logic [ADDR_W-1:0] A_SHARED = ADDR_W'(ADDR_SHARED);
    localparam logic [ADDR_W-1:0] A_SHADOW = ADDR_W'(ADDR_SHADOW);

    logic [DIV_W-1:0] div_d, div_q;
    acc_sel_e         sel;
    logic             unused_wr_hi;

    assign unused_wr_hi = ^wr_data[WORD_W-1:DIV_W];

    always_comb begin
        if (addr == A_SHARED)      sel = dlab ? ACC_DIV : ACC_BUF;
        else if (addr == A_SHADOW) sel = ACC_SHADOW;
        else                       sel = ACC_NONE;

        rd_data = '0;
        if (rd_en) begin
            case (sel)
                ACC_BUF:    rd_data = buf_val;
                ACC_SHADOW: rd_data = buf_val;
                ACC_DIV:    rd_data = WORD_W'(div_q);
                default:    rd_data = '0;
            endcase
        end

        consume = rd_en && (sel == ACC_BUF);
        tx_wr   = wr_en && (sel == ACC_BUF);

        div_d = div_q;
        if (wr_en && (sel == ACC_DIV)) begin
            div_d = wr_data[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= DIV_W'(DIV_RST);
        else        div_q <= div_d;
    end

    assign div_lo = div_q;

    // R7
    div_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dlab && addr == A_SHARED) |=> (div_lo == $past(wr_data[DIV_W-1:0])));

    // R7
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && dlab && addr == A_SHARED) |=> $stable(div_lo));

endmodule

// File: rtl/urb_top.sv
module urb_top #(
    parameter int CHAR_W      = 8,
    parameter int WORD_W      = 32,
    parameter int HI_LSB      = 16,
    parameter int ADDR_W      = 4,
    parameter int DIV_W       = 8,
    parameter int ADDR_SHARED = 0,
    parameter int ADDR_SHADOW = 2,
    parameter int DIV_RST     = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_ninth,
    input  logic              pack_en,
    input  logic              dlab,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              data_ready,
    output logic              overrun,
    output logic              tx_wr,
    output logic [DIV_W-1:0]  div_lo
);
    logic              word_done;
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] buf_val;
    logic              consume;

    urb_packer #(.CHAR_W(CHAR_W), .WORD_W(WORD_W), .HI_LSB(HI_LSB)) u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .pack_en   (pack_en),
        .ch_valid  (rx_valid),
        .ch_data   (rx_char),
        .ch_ext    (rx_ninth),
        .word_done (word_done),
        .word      (word)
    );

    urb_status #(.WORD_W(WORD_W), .CHAR_W(CHAR_W), .HI_LSB(HI_LSB)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_done (word_done),
        .word      (word),
        .consume   (consume),
        .buf_val   (buf_val),
        .ready     (data_ready),
        .ovr       (overrun)
    );

    urb_bus_port #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .DIV_W(DIV_W),
        .ADDR_SHARED(ADDR_SHARED), .ADDR_SHADOW(ADDR_SHADOW), .DIV_RST(DIV_RST)
    ) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .dlab    (dlab),
        .rd_en   (bus_rd),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wr_data (bus_wdata),
        .buf_val (buf_val),
        .rd_data (bus_rdata),
        .consume (consume),
        .tx_wr   (tx_wr),
        .div_lo  (div_lo)
    );

    // R5
    shadow_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(ADDR_SHADOW) && !word_done && !consume)
            |=> ($stable(data_ready) && $stable(overrun)));

    // R6
    tx_keeps_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !word_done && !consume) |=> ($stable(buf_val) && $stable(data_ready)));

endmodule

// File: tb/tb_urb_top.sv
module tb_urb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_char = '0;
    logic        rx_ninth = 1'b0;
    logic        pack_en = 1'b0;
    logic        dlab = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        data_ready;
    logic        overrun;
    logic        tx_wr;
    logic [7:0]  div_lo;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    localparam logic [3:0] A_MAIN = 4'h0;
    localparam logic [3:0] A_SHAD = 4'h2;

    // {pack, first char (9b), second char (9b), expected word}
    localparam int NV = 7;
    localparam logic [50:0] VEC [NV] = '{
        {1'b0, 9'h0A5, 9'h000, 32'h000000A5},
        {1'b0, 9'h1FF, 9'h000, 32'h000001FF},
        {1'b1, 9'h03C, 9'h1C3, 32'h01C3003C},
        {1'b1, 9'h155, 9'h0AA, 32'h00AA0155},
        {1'b1, 9'h1FF, 9'h1FF, 32'h01FF01FF},
        {1'b0, 9'h100, 9'h000, 32'h00000100},
        {1'b1, 9'h000, 9'h101, 32'h01010000}
    };

    urb_top dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
        .rx_ninth(rx_ninth), .pack_en(pack_en), .dlab(dlab), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .data_ready(data_ready), .overrun(overrun),
        .tx_wr(tx_wr), .div_lo(div_lo)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_ch(input logic [8:0] c);
        @(negedge clk);
        rx_valid = 1'b1; rx_char = c[7:0]; rx_ninth = c[8];
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] w, output logic strobe);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = w;
        #1 strobe = tx_wr;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic        s;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 data_ready", 32'(data_ready), 32'd0);
        chk("R1 overrun", 32'(overrun), 32'd0);
        chk("R1 div_lo", 32'(div_lo), 32'd0);
        bus_rd = 1'b1; bus_addr = A_MAIN;
        #1 chk("R1 main read", bus_rdata, 32'd0);
        bus_rd = 1'b0;
        rst_n = 1'b1;

        // vector walk: R2 / R3 / R4 / R5
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            pack_en = VEC[i][50];
            send_ch(VEC[i][49:41]);
            if (VEC[i][50]) begin
                chk("R3 not ready after first", 32'(data_ready), 32'd0);
                send_ch(VEC[i][40:32]);
            end
            chk(VEC[i][50] ? "R3 ready" : "R2 ready", 32'(data_ready), 32'd1);
            bus_read(A_SHAD, d);
            chk("R5 shadow value", d, VEC[i][31:0]);
            chk("R5 still ready", 32'(data_ready), 32'd1);
            bus_read(A_MAIN, d);
            chk(VEC[i][50] ? "R3 word" : "R2 word", d, VEC[i][31:0]);
            chk("R4 cleared", 32'(data_ready), 32'd0);
        end

        // R6 transmit write
        pack_en = 1'b0;
        send_ch(9'h077);
        bus_write(A_MAIN, 32'h0000_00EE, s);
        chk("R6 tx_wr", 32'(s), 32'd1);
        bus_read(A_SHAD, d);
        chk("R6 buffer kept", d, 32'h0000_0077);
        chk("R6 ready kept", 32'(data_ready), 32'd1);

        // R7 divisor access
        dlab = 1'b1;
        bus_write(A_MAIN, 32'hFFFF_FF5A, s);
        chk("R7 no tx_wr", 32'(s), 32'd0);
        chk("R7 div_lo", 32'(div_lo), 32'h5A);
        bus_read(A_MAIN, d);
        chk("R7 read div", d, 32'h0000_005A);
        chk("R7 ready kept", 32'(data_ready), 32'd1);
        dlab = 1'b0;

        // R8 overrun
        send_ch(9'h1C4);
        chk("R8 overrun", 32'(overrun), 32'd1);
        bus_read(A_SHAD, d);
        chk("R8 replaced", d, 32'h0000_01C4);
        bus_read(A_MAIN, d);
        chk("R4 overrun cleared", 32'(overrun), 32'd0);

        // R9 read and completion in the same cycle
        send_ch(9'h011);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = A_MAIN;
        rx_valid = 1'b1; rx_char = 8'h22; rx_ninth = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; rx_valid = 1'b0;
        chk("R9 old word", d, 32'h0000_0011);
        chk("R9 ready", 32'(data_ready), 32'd1);
        chk("R9 no overrun", 32'(overrun), 32'd0);
        bus_read(A_SHAD, d);
        chk("R9 new word", d, 32'h0000_0122);
        bus_read(A_MAIN, d);

        // R10 pending char dropped on pack_en fall
        pack_en = 1'b1;
        send_ch(9'h0AB);
        pack_en = 1'b0;
        send_ch(9'h0CD);
        bus_read(A_MAIN, d);
        chk("R10 only second", d, 32'h0000_00CD);
        pack_en = 1'b1;
        send_ch(9'h012);
        send_ch(9'h134);
        bus_read(A_MAIN, d);
        chk("R10 fresh pair", d, 32'h0134_0012);
        pack_en = 1'b0;

        // R11 other addresses and shadow writes
        send_ch(9'h066);
        bus_read(4'h5, d);
        chk("R11 unmapped read", d, 32'd0);
        bus_write(A_SHAD, 32'h0000_0099, s);
        chk("R11 no tx_wr", 32'(s), 32'd0);
        bus_read(A_SHAD, d);
        chk("R11 shadow unchanged", d, 32'h0000_0066);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule